// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a single burst request into the stream of column addresses that the burst touches, one per clock. A controller or a memory model presents a starting column, a burst-length code and an ordering choice together with a one-cycle start strobe. The block then drives one address per rising edge with a valid flag, and raises a last flag on the final beat of a fixed-length burst.

Two orderings are offered. Sequential ordering counts upward and wraps inside the aligned block of the burst length. Interleaved ordering XORs the beat number into the low column bits. A full-page length, which is legal only with sequential ordering, counts through the whole row modulo 2^COL_W and keeps running until it is stopped or restarted. A stop request ends the burst at once. A fresh start on any cycle replaces the running burst. A length code that is illegal for the chosen ordering produces an error pulse and no addresses.

The control is a three-state machine. `SQ_IDLE` emits nothing. `SQ_FIXED` runs a burst of 1, 2, 4 or 8 beats. `SQ_PAGE` runs a full-page burst. The transitions are as follows. **LAUNCH** goes from any state to `SQ_FIXED` or `SQ_PAGE` on a legal start. **REJECT** goes from any state to `SQ_IDLE` on an illegal start. **ABORT** goes from any state to `SQ_IDLE` on a stop with no start. **FINISH** goes from `SQ_FIXED` to `SQ_IDLE` after the beat that carries last. **ADVANCE** keeps `SQ_FIXED` or `SQ_PAGE` and moves to the next beat.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, valid_o, last_o and err_o are all low.
- R2: A legal start sampled at a rising edge makes that edge present beat 0 (col_o equal to the start column, valid_o high). Each following edge presents the next beat with no idle cycle in between.
- R3: Length codes are 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. btype_i 0 selects sequential ordering and 1 selects interleaved. For a sequential burst of N beats, beat k keeps the bits above log2(N) of the start column, and its low log2(N) bits equal (start + k) mod N.
- R4: For an interleaved burst of N beats, beat k equals the start column XOR k.
- R5: A full-page sequential burst gives beat k = (start + k) mod 512 (COL_W=9). It runs until a stop or a restart and never raises last_o.
- R6: last_o is high exactly on beat N-1 of a fixed burst, and valid_o is low on the cycle after that beat unless a new start arrived.
- R7: A stop request with no start, sampled at an edge, makes valid_o and last_o low from that edge on.
- R8: A legal start during an active burst makes the next edge present beat 0 of the new burst. The old burst is discarded.
- R9: Length codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with interleaved ordering, are illegal. Such a start raises err_o for one cycle with valid_o low and cancels any active burst.
- R10: When start and stop arrive in the same cycle, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst using the inputs below |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst-length code |
| btype_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a fixed burst |
| err_o | output | 1 | Illegal length/ordering pair was requested |

## Verification
The events that can fall in the same cycle are a stop request and a start. The case of a start landing on the beat that carries last is also covered, along with an illegal start landing in the middle of a running burst. The bench raises start and stop together during a live burst and requires the next beat to be beat 0 of the new burst. It also restarts exactly on the last beat, and it fires a rejected code into a full-page run and expects an error pulse with valid low. Each of these is judged against addresses that the bench computes from the start column and the beat number.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FIXED = 2'd1,
        SQ_PAGE  = 2'd2
    } sq_state_e;

    localparam logic [2:0] BLC_1    = 3'b000;
    localparam logic [2:0] BLC_2    = 3'b001;
    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;

endpackage

// File: rtl/sdram_seq_decode.sv
module sdram_seq_decode #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    input  logic             il_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             legal_o
);
    import sdram_seq_pkg::*;

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    always_comb begin
        mask_o  = '0;
        full_o  = 1'b0;
        legal_o = 1'b1;
        unique case (code_i)
            BLC_1:    mask_o = '0;
            BLC_2:    mask_o = COL_W'(1);
            BLC_4:    mask_o = COL_W'(3);
            BLC_8:    mask_o = COL_W'(7);
            BLC_PAGE: begin
                mask_o  = ALL_ONES;
                full_o  = 1'b1;
                legal_o = !il_i;
            end
            default:  legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdram_seq_addr.sv
module sdram_seq_addr #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             il_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] xor_addr;

    always_comb begin
        sum      = base_i + beat_i;
        seq_addr = (base_i & ~mask_i) | (sum & mask_i);
        xor_addr = base_i ^ (beat_i & mask_i);
        addr_o   = il_i ? xor_addr : seq_addr;
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             btype_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    import sdram_seq_pkg::*;

    sq_state_e        state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             il_q, il_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             last_q, last_d;
    logic             err_q, err_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_legal;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] adv_col;

    sdram_seq_decode #(.COL_W(COL_W)) decode_i (
        .code_i  (blen_i),
        .il_i    (btype_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .legal_o (dec_legal)
    );

    assign beat_inc = beat_q + COL_W'(1);

    sdram_seq_addr #(.COL_W(COL_W)) addr_i (
        .base_i (base_q),
        .mask_i (mask_q),
        .il_i   (il_q),
        .beat_i (beat_inc),
        .addr_o (adv_col)
    );

    // next-state and next-output logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        mask_d  = mask_q;
        il_d    = il_q;
        beat_d  = beat_q;
        col_d   = col_q;
        last_d  = 1'b0;
        err_d   = 1'b0;
        if (start_i) begin
            if (dec_legal) begin
                // LAUNCH
                state_d = dec_full ? SQ_PAGE : SQ_FIXED;
                base_d  = start_col_i;
                mask_d  = dec_mask;
                il_d    = btype_i;
                beat_d  = '0;
                col_d   = start_col_i;
                last_d  = !dec_full && (dec_mask == '0);
            end else begin
                // REJECT
                state_d = SQ_IDLE;
                err_d   = 1'b1;
            end
        end else if (stop_i) begin
            // ABORT
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: state_d = SQ_IDLE;
                SQ_FIXED: begin
                    if (last_q) begin
                        // FINISH
                        state_d = SQ_IDLE;
                    end else begin
                        // ADVANCE
                        beat_d = beat_inc;
                        col_d  = adv_col;
                        last_d = (beat_inc == mask_q);
                    end
                end
                SQ_PAGE: begin
                    // ADVANCE
                    beat_d = beat_inc;
                    col_d  = adv_col;
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            il_q    <= 1'b0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            mask_q  <= mask_d;
            il_q    <= il_d;
            beat_q  <= beat_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            last_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            col_q  <= col_d;
            last_q <= last_d;
            err_q  <= err_d;
        end
    end

    assign col_o   = col_q;
    assign valid_o = (state_q != SQ_IDLE);
    assign last_o  = last_q;
    assign err_o   = err_q;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_i,
    input logic             btype_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic legal_req;
    assign legal_req = (blen_i[2] == 1'b0) || (blen_i == 3'b111 && !btype_i);

    // R6
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R9
    err_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    // R7
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o && !last_o));

    // R2
    start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && legal_req) |=> (valid_o && col_o == $past(start_col_i) && !err_o));

    // R2
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);

    // R5
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && blen_i == 3'b111 && !btype_i) |=> !last_o);

    // R9
    illegal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !legal_req) |=> (err_o && !valid_o));

    // R6
    after_last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .btype_i     (btype_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/sdram_col_seq_tb_top.sv
module sdram_col_seq_tb_top;
    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             btype_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_col_seq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .btype_i(btype_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int base, int n, bit il, int k);
        if (il) return base ^ k;
        return (base - (base % n)) + ((base % n + k) % n);
    endfunction

    function automatic int code_len(logic [2:0] c);
        return (c == 3'b111) ? PAGE : (1 << c);
    endfunction

    // drive a start at a negedge; outputs show beat 0 at the next negedge
    task automatic issue(input int col, input logic [2:0] code, input bit il, input bit stp);
        start_i = 1'b1; start_col_i = COL_W'(col); blen_i = code; btype_i = il; stop_i = stp;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic run_fixed(input int col, input logic [2:0] code, input bit il, input string req);
        int n;
        n = code_len(code);
        issue(col, code, il, 1'b0);
        for (int k = 0; k < n; k++) begin
            check({req, " valid"}, valid_o, 1);
            check({req, " col"}, col_o, exp_col(col, n, il, k));
            check("R6 last", last_o, (k == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R6 idle after last", valid_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1 valid", valid_o, 0);
        check("R1 last", last_o, 0);
        check("R1 err", err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", valid_o, 0);

        // sweep every column for fixed lengths and both orderings
        for (int il = 0; il < 2; il++)
            for (int c = 0; c < 4; c++)
                for (int col = 0; col < PAGE; col += (c == 0 ? 37 : 1))
                    run_fixed(col, 3'(c), il[0], il ? "R4" : "R3");

        // full page with wrap, R5
        issue(500, 3'b111, 1'b0, 1'b0);
        for (int k = 0; k < 600; k++) begin
            check("R5 valid", valid_o, 1);
            check("R5 col", col_o, (500 + k) % PAGE);
            check("R5 last", last_o, 0);
            @(negedge clk);
        end
        // stop, R7
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        check("R7 valid", valid_o, 0);
        check("R7 last", last_o, 0);
        @(negedge clk);
        check("R7 still idle", valid_o, 0);

        // stop in middle of a fixed burst
        issue(10, 3'b011, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 mid col", col_o, 10 ^ 1);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        check("R7 mid valid", valid_o, 0);

        // restart mid burst, R8
        issue(40, 3'b011, 1'b0, 1'b0);
        @(negedge clk); @(negedge clk);
        issue(77, 3'b010, 1'b1, 1'b0);
        check("R8 col", col_o, 77);
        check("R8 valid", valid_o, 1);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check("R8 seq", col_o, 77 ^ k);
        end
        check("R8 last", last_o, 1);
        // restart on last beat, R8
        issue(3, 3'b001, 1'b0, 1'b0);
        check("R8 on last col", col_o, 3);
        check("R8 on last valid", valid_o, 1);
        @(negedge clk);
        check("R8 on last beat1", col_o, 2);
        check("R6 last len2", last_o, 1);
        @(negedge clk);

        // start and stop together, R10
        issue(200, 3'b111, 1'b0, 1'b0);
        @(negedge clk);
        issue(300, 3'b011, 1'b0, 1'b1);
        check("R10 valid", valid_o, 1);
        check("R10 col", col_o, 300);
        @(negedge clk);
        check("R10 beat1", col_o, 301);

        // illegal codes, R9
        for (int c = 4; c < 8; c++) begin
            for (int il = 0; il < 2; il++) begin
                if (c == 7 && il == 0) continue;
                issue(123, 3'b111, 1'b0, 1'b0);
                @(negedge clk);
                issue(55, 3'(c), il[0], 1'b0);
                check("R9 err", err_o, 1);
                check("R9 valid", valid_o, 0);
                @(negedge clk);
                check("R9 err pulse", err_o, 0);
                check("R9 cancelled", valid_o, 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule